// File: doc/BRIEF.md
# Bidirectional Neighbour Shift-Register Row

This block is a row of word registers with one register for each processing column of a SIMD array. Each column holds one pixel-sized word. All columns receive the same 5-bit operation code every clock cycle and perform the same operation on their own word.

The operation can do one of four things:
- move every word one column toward the higher or lower index, filling the vacated edge with zero;
- rotate the row so that the edge word wraps around to the other end;
- load all words in parallel from an external source;
- give single-bit access to each column's one-bit serial bus.

Through the bus, a pixel can be written bit by bit and read back bit by bit. A pixel written in eight bus cycles reaches a neighbour after one more shift cycle. The neighbour can then combine it with its own data.

Column `c` occupies bits `[c*8 +: 8]` of the packed word vectors. "Right" means toward the higher column index.

Top module: `nbr_shift_row`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every column word is cleared to zero at that edge. After reset, the bus enable is low.
- R2: Code 0 moves each word one column right (column c takes column c-1's word). Column 0 is filled with zero.
- R3: Code 1 moves each word one column left (column c takes column c+1's word). The last column is filled with zero.
- R4: Code 2 loads every column word from its slice of `load_words`.
- R5: Code 3 rotates the row right, with the last column's word wrapping into column 0.
- R6: Code 4 rotates the row left, with column 0's word wrapping into the last column.
- R7: Code 5+k (k = 0..7) writes `bus_in[c]` into bit k of column c's word and leaves the other seven bits unchanged.
- R8: During code 13+k (k = 0..7), `bus_oe` is high and `bus_out[c]` shows bit k of column c's word in the same cycle, without a clock edge.
- R9: For every code outside 13..20, `bus_oe` is low and `bus_out` is all zero.
- R10: Codes 13..20 and codes 21..31 leave every column word unchanged.
- R11: A pixel written into a column through eight bus-write cycles (codes 5..12) appears in the right-hand neighbour's word after one further code-0 cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 5 | Broadcast operation code, applied by all columns |
| load_words | input | NCOLS*8 | Parallel load value for code 2, column c at [c*8 +: 8] |
| bus_in | input | NCOLS | Per-column serial bus bit used by the write codes |
| bus_out | output | NCOLS | Per-column bit driven during the read codes, zero otherwise |
| bus_oe | output | 1 | High while a read code drives the bus |
| row_words | output | NCOLS*8 | Current column words, column c at [c*8 +: 8] |

## Verification
The checker compares the row after every cycle with the row from the cycle before. It does this for the shift, rotate, latch and hold codes. It also confirms on every cycle that the bus enable is high only for the read codes and that a released bus carries zeros. Single-bit writes, same-cycle bit selection on reads, and the eight-writes-then-shift pixel path depend on the per-bit bus pattern. Only the bench's directed scenarios cover them, using a model row built from the requirements.

// File: rtl/nsr_pkg.sv
// Package: shared constants and types for the neighbour shift-register row.
// Assumes an 8-bit word and a 5-bit broadcast operation code.
package nsr_pkg;
    localparam int WORD_W  = 8;
    localparam int OP_W    = 5;
    localparam int SEL_W   = $clog2(WORD_W);
    localparam int CODE_SHR   = 0;
    localparam int CODE_SHL   = 1;
    localparam int CODE_LATCH = 2;
    localparam int CODE_ROR   = 3;
    localparam int CODE_ROL   = 4;
    localparam int WR_BASE    = 5;
    localparam int RD_BASE    = WR_BASE + WORD_W;
    localparam int RD_LAST    = RD_BASE + WORD_W - 1;

    typedef enum logic [2:0] {
        OPK_NOP,
        OPK_SHR,
        OPK_SHL,
        OPK_LATCH,
        OPK_ROR,
        OPK_ROL,
        OPK_WR,
        OPK_RD
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [SEL_W-1:0] bit_sel;
    } row_ctrl_t;
endpackage

// File: rtl/nsr_decode.sv
// Module: nsr_decode
// Turns the broadcast operation code into an operation kind and a bit index.
// Assumes the codes are laid out as in nsr_pkg; unused codes decode to no-op.
module nsr_decode
    import nsr_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output row_ctrl_t       ctrl
);
    logic [OP_W-1:0] wr_off;
    logic [OP_W-1:0] rd_off;

    // Offsets of the code within the write and read windows
    assign wr_off = op_code - OP_W'(WR_BASE);
    assign rd_off = op_code - OP_W'(RD_BASE);

    // Classify the code and extract the selected bit position
    always_comb begin
        ctrl.kind    = OPK_NOP;
        ctrl.bit_sel = '0;
        if (op_code == OP_W'(CODE_SHR)) begin
            ctrl.kind = OPK_SHR;
        end else if (op_code == OP_W'(CODE_SHL)) begin
            ctrl.kind = OPK_SHL;
        end else if (op_code == OP_W'(CODE_LATCH)) begin
            ctrl.kind = OPK_LATCH;
        end else if (op_code == OP_W'(CODE_ROR)) begin
            ctrl.kind = OPK_ROR;
        end else if (op_code == OP_W'(CODE_ROL)) begin
            ctrl.kind = OPK_ROL;
        end else if (op_code >= OP_W'(WR_BASE) && op_code < OP_W'(RD_BASE)) begin
            ctrl.kind    = OPK_WR;
            ctrl.bit_sel = wr_off[SEL_W-1:0];
        end else if (op_code >= OP_W'(RD_BASE) && op_code <= OP_W'(RD_LAST)) begin
            ctrl.kind    = OPK_RD;
            ctrl.bit_sel = rd_off[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/nsr_column.sv
// Module: nsr_column
// One column's word register. It takes a neighbour word on shifts and
// rotates, the parallel word on latch, or one bus bit on a bit write, and
// presents the selected bit for bus reads.
// Assumes the row level supplies zero or the wrapped word at the edges.
module nsr_column
    import nsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  row_ctrl_t         ctrl,
    input  logic [WORD_W-1:0] from_lower,
    input  logic [WORD_W-1:0] from_upper,
    input  logic [WORD_W-1:0] load_word,
    input  logic              bus_bit,
    output logic [WORD_W-1:0] word_q,
    output logic              rd_bit
);
    logic [WORD_W-1:0] word_d;

    // Select the next word for this column from the decoded operation
    always_comb begin
        word_d = word_q;
        unique case (ctrl.kind)
            OPK_SHR, OPK_ROR: word_d = from_lower;
            OPK_SHL, OPK_ROL: word_d = from_upper;
            OPK_LATCH:        word_d = load_word;
            OPK_WR:           word_d[ctrl.bit_sel] = bus_bit;
            default:          word_d = word_q;
        endcase
    end

    // Word register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    // Selected bit toward the bus, forced to zero outside reads
    assign rd_bit = (ctrl.kind == OPK_RD) ? word_q[ctrl.bit_sel] : 1'b0;
endmodule

// File: rtl/nbr_shift_row.sv
// Module: nbr_shift_row
// Row of NCOLS word registers under one broadcast operation code. It wires
// each column to its neighbours and picks zero fill or wrap-around at the two
// row ends.
// Assumes right = toward higher column index; column c sits at [c*W +: W].
module nbr_shift_row
    import nsr_pkg::*;
#(
    parameter int NCOLS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OP_W-1:0]         op_code,
    input  logic [NCOLS*WORD_W-1:0] load_words,
    input  logic [NCOLS-1:0]        bus_in,
    output logic [NCOLS-1:0]        bus_out,
    output logic                    bus_oe,
    output logic [NCOLS*WORD_W-1:0] row_words
);
    localparam int LAST = NCOLS - 1;

    row_ctrl_t         ctrl;
    logic [WORD_W-1:0] words    [NCOLS];
    logic [WORD_W-1:0] lower_in [NCOLS];
    logic [WORD_W-1:0] upper_in [NCOLS];
    logic [NCOLS-1:0]  rd_bits;

    nsr_decode u_decode (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    for (genvar g = 0; g < NCOLS; g++) begin : g_col
        // Lower-side neighbour: zero fill or wrap from the last column at the edge
        if (g == 0) begin : g_lo_edge
            assign lower_in[g] = (ctrl.kind == OPK_ROR) ? words[LAST] : '0;
        end else begin : g_lo_mid
            assign lower_in[g] = words[g-1];
        end

        // Upper-side neighbour: zero fill or wrap from column 0 at the edge
        if (g == LAST) begin : g_hi_edge
            assign upper_in[g] = (ctrl.kind == OPK_ROL) ? words[0] : '0;
        end else begin : g_hi_mid
            assign upper_in[g] = words[g+1];
        end

        nsr_column u_col (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl       (ctrl),
            .from_lower (lower_in[g]),
            .from_upper (upper_in[g]),
            .load_word  (load_words[g*WORD_W +: WORD_W]),
            .bus_bit    (bus_in[g]),
            .word_q     (words[g]),
            .rd_bit     (rd_bits[g])
        );

        // Expose the column word on the packed row output
        assign row_words[g*WORD_W +: WORD_W] = words[g];
    end

    // The bus is driven only while a read code is present
    assign bus_out = rd_bits;
    assign bus_oe  = (ctrl.kind == OPK_RD);
endmodule

// File: rtl/nsr_row_chk.sv
// Module: nsr_row_chk
// Checker bound to nbr_shift_row. It keeps a one-cycle copy of the row, the
// code and the load value, then compares each new row against them.
// Assumes the code layout from nsr_pkg.
module nsr_row_chk
    import nsr_pkg::*;
#(
    parameter int NCOLS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [OP_W-1:0]         op_code,
    input logic [NCOLS*WORD_W-1:0] load_words,
    input logic [NCOLS-1:0]        bus_out,
    input logic                    bus_oe,
    input logic [NCOLS*WORD_W-1:0] row_words
);
    localparam int TOT = NCOLS * WORD_W;

    logic                    prev_ok = 1'b0;
    logic                    was_rst = 1'b0;
    logic [TOT-1:0]          prev_words;
    logic [TOT-1:0]          prev_load;
    logic [OP_W-1:0]         prev_op;
    logic                    is_read;
    logic                    was_hold;

    // One-cycle history of the row, the code and the load value
    always_ff @(posedge clk) begin
        was_rst    <= !rst_n;
        prev_ok    <= rst_n;
        prev_words <= row_words;
        prev_load  <= load_words;
        prev_op    <= op_code;
    end

    assign is_read  = (op_code >= OP_W'(RD_BASE)) && (op_code <= OP_W'(RD_LAST));
    assign was_hold = (prev_op >= OP_W'(RD_BASE));

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (row_words == '0));                                          // R1
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && prev_op == OP_W'(CODE_SHR)) |-> (row_words == (prev_words << WORD_W)));  // R2
    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && prev_op == OP_W'(CODE_SHL)) |-> (row_words == (prev_words >> WORD_W)));  // R3
    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && prev_op == OP_W'(CODE_LATCH)) |-> (row_words == prev_load));  // R4
    AST_ROTATE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && prev_op == OP_W'(CODE_ROR)) |->
        (row_words == {prev_words[TOT-WORD_W-1:0], prev_words[TOT-1 -: WORD_W]})); // R5
    AST_ROTATE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && prev_op == OP_W'(CODE_ROL)) |->
        (row_words == {prev_words[WORD_W-1:0], prev_words[TOT-1:WORD_W]}));        // R6
    AST_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |-> bus_oe);                                                     // R8
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |-> (!bus_oe && bus_out == '0));                                // R9
    AST_HOLD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && was_hold) |-> (row_words == prev_words));                    // R10
endmodule

bind nbr_shift_row nsr_row_chk #(.NCOLS(NCOLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_code    (op_code),
    .load_words (load_words),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .row_words  (row_words)
);

// File: tb/nbr_shift_row_tb.sv
module nbr_shift_row_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [4:0]     op_code = 5'd31;
    logic [N*W-1:0] load_words = '0;
    logic [N-1:0]   bus_in = '0;
    logic [N-1:0]   bus_out;
    logic           bus_oe;
    logic [N*W-1:0] row_words;

    logic [W-1:0] exp_w [N];
    logic [W-1:0] pix   [N];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nbr_shift_row #(.NCOLS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .load_words(load_words),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .row_words(row_words)
    );

    task automatic check_row(input string req);
        logic [N*W-1:0] e;
        for (int c = 0; c < N; c++) e[c*W +: W] = exp_w[c];
        checks++;
        if (row_words !== e) begin
            errors++;
            $display("FAIL %s row actual=%h expected=%h", req, row_words, e);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_released(input string req);
        checks++;
        if (bus_oe !== 1'b0 || bus_out !== '0) begin
            errors++;
            $display("FAIL %s bus actual oe=%b out=%h expected oe=0 out=0", req, bus_oe, bus_out);
        end
    endtask

    task automatic step(input logic [4:0] op);
        @(negedge clk);
        op_code = op;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(5'd0);
        rst_n = 1'b1;
        for (int c = 0; c < N; c++) exp_w[c] = '0;
        check_row("R1");
        check_released("R1");
    endtask

    task automatic t_latch(input logic [N*W-1:0] v);
        load_words = v;
        step(5'd2);
        for (int c = 0; c < N; c++) exp_w[c] = v[c*W +: W];
        check_row("R4");
    endtask

    task automatic t_shift_right;
        step(5'd0);
        for (int c = N-1; c > 0; c--) exp_w[c] = exp_w[c-1];
        exp_w[0] = '0;
        check_row("R2");
        check_released("R9");
    endtask

    task automatic t_shift_left;
        step(5'd1);
        for (int c = 0; c < N-1; c++) exp_w[c] = exp_w[c+1];
        exp_w[N-1] = '0;
        check_row("R3");
        check_released("R9");
    endtask

    task automatic t_rot_right;
        logic [W-1:0] t;
        step(5'd3);
        t = exp_w[N-1];
        for (int c = N-1; c > 0; c--) exp_w[c] = exp_w[c-1];
        exp_w[0] = t;
        check_row("R5");
    endtask

    task automatic t_rot_left;
        logic [W-1:0] t;
        step(5'd4);
        t = exp_w[0];
        for (int c = 0; c < N-1; c++) exp_w[c] = exp_w[c+1];
        exp_w[N-1] = t;
        check_row("R6");
    endtask

    task automatic t_pixel_load;
        for (int c = 0; c < N; c++) pix[c] = W'(8'h5A ^ (c * 37));
        for (int k = 0; k < W; k++) begin
            for (int c = 0; c < N; c++) bus_in[c] = pix[c][k];
            step(5'(5 + k));
            for (int c = 0; c < N; c++) exp_w[c][k] = pix[c][k];
            if (k == 2 || k == W-1) check_row("R7");
        end
        step(5'd0);
        for (int c = N-1; c > 0; c--) exp_w[c] = exp_w[c-1];
        exp_w[0] = '0;
        check_row("R11");
        checks++;
        if (row_words[W +: W] !== pix[0]) begin
            errors++;
            $display("FAIL R11 neighbour actual=%h expected=%h", row_words[W +: W], pix[0]);
        end
    endtask

    task automatic t_read_bits;
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            op_code = 5'(13 + k);
            #1;
            check_bit("R8 oe", bus_oe, 1'b1);
            for (int c = 0; c < N; c++) check_bit("R8 bit", bus_out[c], exp_w[c][k]);
            @(posedge clk);
            #1;
            check_row("R10");
        end
    endtask

    task automatic t_nops;
        step(5'd21);
        check_row("R10");
        check_released("R9");
        step(5'd31);
        check_row("R10");
        check_released("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_latch(64'h8877_6655_4433_2211);
        t_shift_right();
        t_shift_left();
        t_latch(64'hF0E1_D2C3_B4A5_9687);
        t_rot_right();
        t_rot_right();
        t_rot_left();
        t_shift_left();
        t_latch(64'h0000_0000_0000_0000);
        t_pixel_load();
        t_read_bits();
        t_nops();
        t_latch(64'hDEAD_BEEF_0123_4567);
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule